// File: doc/BRIEF.md
# Rotating Register File Mapper

This block is a small register file whose register numbers are translated before every access, so that a software-pipelined loop can use the same register numbers in every iteration and still get a fresh set of storage. The register space is split at a boundary. Numbers below the boundary are static and address storage directly. Numbers at or above it form the rotating region. For these numbers the offset into the region is added to a base value, and the sum wraps within the region size.

The base value moves down by one on each loop-closing branch pulse (`rot_step`). A value written under number `s` in one iteration can therefore be read under number `s+k` after `k` further iterations. A producer-to-consumer distance of `k` iterations is encoded as a difference of `k` between the two register numbers. A synchronous clear (`rot_clear`) returns the base to zero on loop entry.

There are two asynchronous read ports and one write port. All three use the base that is current in the cycle of the access. The base controller works as a three-action machine with these actions:
- HOLD: no pulse, so the base keeps its value.
- STEP: the base is decremented, and 0 wraps to ROT_COUNT-1.
- CLEAR: the base becomes 0. CLEAR wins over STEP when both pulses arrive together.

Top module: `rrf_rotating_regfile`

## Requirements
- R1: After reset the base is 0 and every register reads as 0 on both read ports.
- R2: A register number below ROT_BASE addresses storage entry equal to that number, whatever the base, so a value written there reads back unchanged after any number of steps.
- R3: A register number s at or above ROT_BASE addresses storage entry ROT_BASE + ((s - ROT_BASE + base) mod ROT_COUNT). ROT_COUNT equals NUM_REGS - ROT_BASE.
- R4: Each cycle with `rot_step` high and `rot_clear` low decrements the base by one, and 0 becomes ROT_COUNT-1. A value written under rotating number s is then read k steps later under the rotating number whose offset is (s - ROT_BASE + k) mod ROT_COUNT.
- R5: A cycle with `rot_clear` high sets the base to 0 for the next cycle, even when `rot_step` is also high.
- R6: A write in the same cycle as a step or a clear is placed using the base value from before that update.
- R7: A read of the register being written in the same cycle returns the value held before the write. The new value is visible from the next cycle on.
- R8: The two read ports translate and read independently, so different numbers on the two ports return their own registers in the same cycle.
- R9: In a cycle with neither `rot_step` nor `rot_clear`, the base keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rot_clear | input | 1 | Loop-entry pulse, sets the base to 0 |
| rot_step | input | 1 | Loop-branch pulse, decrements the base |
| wr_en | input | 1 | Write enable |
| wr_spec | input | SPEC_W | Register number for the write |
| wr_data | input | DATA_W | Write data |
| rd0_spec | input | SPEC_W | Register number for read port 0 |
| rd0_data | output | DATA_W | Read data for port 0 (combinational) |
| rd1_spec | input | SPEC_W | Register number for read port 1 |
| rd1_data | output | DATA_W | Read data for port 1 (combinational) |

## Verification
Two operations can fall in the same cycle: a write, and a base update (a step or a clear). The bench drives both pulses together with a write into the rotating region. It then reads back under the number that the pre-update base predicts, and under the post-update base, and compares against an arithmetic model. The bench also raises a clear and a step together to confirm that the clear wins. It places a read and a write on the same register in one cycle to confirm that the read returns the old value. A full sweep writes and reads every register number at every base value through one complete wrap.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

    // Action taken on the rotating base in a given cycle
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_CLEAR = 2'd2
    } rrb_act_e;

endpackage

// File: rtl/rrf_base_ctrl.sv
module rrf_base_ctrl
    import rrf_pkg::*;
#(
    parameter int ROT_COUNT = 8,
    localparam int RRB_W = (ROT_COUNT > 1) ? $clog2(ROT_COUNT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rot_clear,
    input  logic             rot_step,
    output logic [RRB_W-1:0] rrb_q
);

    localparam logic [RRB_W-1:0] RRB_TOP = RRB_W'(ROT_COUNT - 1);

    rrb_act_e         act;
    logic [RRB_W-1:0] rrb_d;

    // Action decode: a clear has priority over a step
    always_comb begin
        if (rot_clear)      act = ACT_CLEAR;
        else if (rot_step)  act = ACT_STEP;
        else                act = ACT_HOLD;
    end

    // Next-base selection
    always_comb begin
        unique case (act)
            ACT_CLEAR: rrb_d = '0;
            ACT_STEP:  rrb_d = (rrb_q == '0) ? RRB_TOP : rrb_q - 1'b1;
            default:   rrb_d = rrb_q;
        endcase
    end

    // Base register
    always_ff @(posedge clk) begin
        if (!rst_n) rrb_q <= '0;
        else        rrb_q <= rrb_d;
    end

endmodule

// File: rtl/rrf_spec_map.sv
module rrf_spec_map #(
    parameter int NUM_REGS = 16,
    parameter int ROT_BASE = 8,
    localparam int ROT_COUNT = NUM_REGS - ROT_BASE,
    localparam int SPEC_W = $clog2(NUM_REGS),
    localparam int RRB_W = (ROT_COUNT > 1) ? $clog2(ROT_COUNT) : 1
) (
    input  logic [SPEC_W-1:0] spec,
    input  logic [RRB_W-1:0]  rrb,
    output logic [SPEC_W-1:0] phys
);

    localparam int SUM_W = SPEC_W + 1;
    localparam logic [SUM_W-1:0] BASE_S  = SUM_W'(ROT_BASE);
    localparam logic [SUM_W-1:0] COUNT_S = SUM_W'(ROT_COUNT);

    logic [SUM_W-1:0] offs;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] wrapped;

    always_comb begin
        offs    = SUM_W'(spec) - BASE_S;
        sum     = offs + SUM_W'(rrb);
        wrapped = (sum >= COUNT_S) ? (sum - COUNT_S) : sum;
        if (SUM_W'(spec) < BASE_S) phys = spec;
        else                       phys = SPEC_W'(wrapped + BASE_S);
    end

endmodule

// File: rtl/rrf_storage.sv
module rrf_storage #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 16,
    localparam int SPEC_W  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SPEC_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SPEC_W-1:0] raddr0,
    output logic [DATA_W-1:0] rdata0,
    input  logic [SPEC_W-1:0] raddr1,
    output logic [DATA_W-1:0] rdata1
);

    logic [DATA_W-1:0] mem [NUM_REGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Reads see storage contents before any same-cycle write
    assign rdata0 = mem[raddr0];
    assign rdata1 = mem[raddr1];

endmodule

// File: rtl/rrf_rotating_regfile.sv
module rrf_rotating_regfile #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 16,
    parameter int ROT_BASE = 8,
    localparam int ROT_COUNT = NUM_REGS - ROT_BASE,
    localparam int SPEC_W = $clog2(NUM_REGS),
    localparam int RRB_W = (ROT_COUNT > 1) ? $clog2(ROT_COUNT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rot_clear,
    input  logic              rot_step,
    input  logic              wr_en,
    input  logic [SPEC_W-1:0] wr_spec,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SPEC_W-1:0] rd0_spec,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [SPEC_W-1:0] rd1_spec,
    output logic [DATA_W-1:0] rd1_data
);

    localparam int NPORT = 3; // index 0: write, 1: read0, 2: read1

    logic [RRB_W-1:0]  rrb_q;
    logic [SPEC_W-1:0] lspec [NPORT];
    logic [SPEC_W-1:0] pidx  [NPORT];

    assign lspec[0] = wr_spec;
    assign lspec[1] = rd0_spec;
    assign lspec[2] = rd1_spec;

    rrf_base_ctrl #(.ROT_COUNT(ROT_COUNT)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rot_clear (rot_clear),
        .rot_step  (rot_step),
        .rrb_q     (rrb_q)
    );

    // All ports translate with the base current in this cycle
    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rrf_spec_map #(.NUM_REGS(NUM_REGS), .ROT_BASE(ROT_BASE)) u_map (
            .spec (lspec[p]),
            .rrb  (rrb_q),
            .phys (pidx[p])
        );
    end

    rrf_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en),
        .waddr  (pidx[0]),
        .wdata  (wr_data),
        .raddr0 (pidx[1]),
        .rdata0 (rd0_data),
        .raddr1 (pidx[2]),
        .rdata1 (rd1_data)
    );

endmodule

// File: rtl/rrf_checker.sv
module rrf_checker #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 16,
    parameter int ROT_BASE = 8,
    localparam int ROT_COUNT = NUM_REGS - ROT_BASE,
    localparam int SPEC_W = $clog2(NUM_REGS),
    localparam int RRB_W = (ROT_COUNT > 1) ? $clog2(ROT_COUNT) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rot_clear,
    input logic              rot_step,
    input logic              wr_en,
    input logic [SPEC_W-1:0] wr_spec,
    input logic [DATA_W-1:0] wr_data,
    input logic [SPEC_W-1:0] rd0_spec,
    input logic [DATA_W-1:0] rd0_data,
    input logic [RRB_W-1:0]  rrb
);

    // Number that reaches the same storage one step later
    function automatic logic [SPEC_W-1:0] bump(input logic [SPEC_W-1:0] s);
        int o;
        o = (int'(s) - ROT_BASE + 1) % ROT_COUNT;
        return SPEC_W'(ROT_BASE + o);
    endfunction

    // R5: clear wins and zeroes the base
    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rot_clear |=> (rrb == '0));

    // R4: a step decrements with wrap
    p_step_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_step && !rot_clear) |=>
        (rrb == (($past(rrb) == '0) ? RRB_W'(ROT_COUNT - 1) : RRB_W'($past(rrb) - 1'b1))));

    // R9: no pulse keeps the base
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rot_step && !rot_clear) |=> $stable(rrb));

    // R2: static numbers read back what was written
    p_static_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && (int'($past(wr_spec)) < ROT_BASE) && (rd0_spec == $past(wr_spec)))
        |-> (rd0_data == $past(wr_data)));

    // R3: rotating number with unchanged base reads back the write
    p_rot_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && !$past(rot_step) && !$past(rot_clear) &&
         (int'($past(wr_spec)) >= ROT_BASE) && (rd0_spec == $past(wr_spec)))
        |-> (rd0_data == $past(wr_data)));

    // R6: write during a step used the pre-step base
    p_wr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && $past(rot_step) && !$past(rot_clear) &&
         (int'($past(wr_spec)) >= ROT_BASE) && (rd0_spec == bump($past(wr_spec))))
        |-> (rd0_data == $past(wr_data)));

endmodule

bind rrf_rotating_regfile rrf_checker #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ROT_BASE(ROT_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rot_clear(rot_clear), .rot_step(rot_step),
    .wr_en(wr_en), .wr_spec(wr_spec), .wr_data(wr_data),
    .rd0_spec(rd0_spec), .rd0_data(rd0_data), .rrb(rrb_q)
);

// File: tb/tb_rrf_rotating_regfile.sv
`timescale 1ns/1ps
module tb_rrf_rotating_regfile;

    localparam int DW = 16;
    localparam int NR = 16;
    localparam int RB = 8;
    localparam int RC = NR - RB;
    localparam int SW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rot_clear = 1'b0, rot_step = 1'b0, wr_en = 1'b0;
    logic [SW-1:0] wr_spec = '0, rd0_spec = '0, rd1_spec = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd0_data, rd1_data;

    int checks = 0;
    int errors = 0;
    int mrrb = 0;
    logic [DW-1:0] model [NR];

    always #4 clk = ~clk;

    rrf_rotating_regfile #(.DATA_W(DW), .NUM_REGS(NR), .ROT_BASE(RB)) dut (
        .clk(clk), .rst_n(rst_n), .rot_clear(rot_clear), .rot_step(rot_step),
        .wr_en(wr_en), .wr_spec(wr_spec), .wr_data(wr_data),
        .rd0_spec(rd0_spec), .rd0_data(rd0_data),
        .rd1_spec(rd1_spec), .rd1_data(rd1_data)
    );

    function automatic int map_idx(input int s, input int b);
        if (s < RB) return s;
        return RB + ((s - RB + b) % RC);
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge: drive one cycle, update the model, return idle
    task automatic cyc(input bit we, input int ws, input logic [DW-1:0] wd,
                       input bit st, input bit cl);
        wr_en = we; wr_spec = SW'(ws); wr_data = wd; rot_step = st; rot_clear = cl;
        @(posedge clk);
        if (we) model[map_idx(ws, mrrb)] = wd;
        if (cl)      mrrb = 0;
        else if (st) mrrb = (mrrb + RC - 1) % RC;
        @(negedge clk);
        wr_en = 1'b0; rot_step = 1'b0; rot_clear = 1'b0;
    endtask

    task automatic rd(input int s0, input int s1, input string req);
        rd0_spec = SW'(s0); rd1_spec = SW'(s1);
        #1;
        chk(req, rd0_data, model[map_idx(s0, mrrb)]);
        chk(req, rd1_data, model[map_idx(s1, mrrb)]);
    endtask

    task automatic rd_exp(input int s, input logic [DW-1:0] exp, input string req);
        rd0_spec = SW'(s);
        #1;
        chk(req, rd0_data, exp);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NR; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents and base zero
        for (int s = 0; s < NR; s++) rd(s, NR - 1 - s, "R1");

        // R3 R8: full sweep over every base value through one wrap
        for (int it = 0; it <= RC; it++) begin
            for (int s = 0; s < NR; s++) cyc(1, s, DW'((it << 8) | (s << 4) | 4'h5), 0, 0);
            for (int s = 0; s < NR; s++) rd(s, NR - 1 - s, "R3 R8");
            cyc(0, 0, '0, 1, 0);
        end

        // R9: idle cycles leave the mapping unchanged
        repeat (4) cyc(0, 0, '0, 0, 0);
        for (int s = RB; s < NR; s++) rd(s, s, "R9");

        // R4: forward distance, then wrap inside the region
        cyc(0, 0, '0, 0, 1);
        cyc(1, 9, 16'hA001, 0, 0);
        repeat (3) cyc(0, 0, '0, 1, 0);
        rd_exp(12, 16'hA001, "R4");
        cyc(1, 14, 16'hA002, 0, 0);
        repeat (3) cyc(0, 0, '0, 1, 0);
        rd_exp(9, 16'hA002, "R4");

        // R2: static number unaffected by steps
        cyc(1, 3, 16'hB003, 0, 0);
        repeat (5) cyc(0, 0, '0, 1, 0);
        rd_exp(3, 16'hB003, "R2");

        // R5: clear with step together gives base zero
        cyc(0, 0, '0, 0, 1);
        repeat (2) cyc(0, 0, '0, 1, 0);      // base 6
        cyc(1, 8, 16'hC004, 0, 0);           // storage entry 14
        cyc(0, 0, '0, 1, 1);
        rd_exp(14, 16'hC004, "R5");
        rd(8, 15, "R5");

        // R6: write during step uses pre-step base
        cyc(1, 9, 16'hD005, 1, 0);           // base 0 -> 7
        rd_exp(10, 16'hD005, "R6");
        // R6: write during clear at base 7 lands on entry 8
        cyc(1, 9, 16'hD006, 0, 1);
        rd_exp(8, 16'hD006, "R6");

        // R7: same-cycle read returns the old value
        cyc(1, 11, 16'hE007, 0, 0);
        wr_en = 1'b1; wr_spec = SW'(11); wr_data = 16'hE008; rd0_spec = SW'(11);
        #1;
        chk("R7", rd0_data, 16'hE007);
        cyc(1, 11, 16'hE008, 0, 0);
        rd_exp(11, 16'hE008, "R7");

        finish_run();
    end

endmodule